// File: doc/BRIEF.md
# Protected Channel Value Buffer

This block holds the 6-bit quantized channel reliability values that an iterative belief-propagation decoder reads again on every iteration, and guards them against single-event upsets in storage. Each value is written together with a second copy of its sign-carrying top bit, giving a 7-bit codeword per location. On every read the two copies are compared. When they disagree, the block drops the value and returns zero, an erasure, so the decoder treats that position as carrying no channel information and lets later iterations recover it. Upsets in the five lower bits are not detected; the decoder's own tolerance absorbs them.

The storage is a synchronous single-port array with one cycle of read latency and a depth set by a parameter. A flag marks each erased read in the same cycle as the zeroed data, and a saturating counter totals the erasures since reset. A fault-injection mask on the write path lets a test corrupt any chosen bits of the stored codeword. This stands in for an upset that strikes the word while it sits in storage.

Top module: `llr_guard_buffer`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` and `erase_flag` are 0 and `erase_count` is 0 until the first erasure occurs.
- R2: A value written to an address with a zero `flip_mask` is returned unchanged on `rd_data` by a later read of that address.
- R3: A read accepted on a clock edge (`rd_en` high, `wr_en` low) raises `rd_valid` for exactly the following cycle. When `wr_en` and `rd_en` are both high, the write is performed and no read occurs.
- R4: The stored codeword holds the value in bits 5..0 and the duplicate of value bit 5 in bit 6. When exactly one of codeword bits 5 and 6 is inverted, the read returns `rd_data` = 0 with `erase_flag` = 1 in the `rd_valid` cycle.
- R5: When only codeword bits 4..0 are inverted, the read returns the corrupted value (written value XOR the mask's low bits) with `erase_flag` = 0.
- R6: When both codeword bits 5 and 6 are inverted, the copies agree. The read then returns the written value with bit 5 inverted, and `erase_flag` = 0.
- R7: `erase_count` rises by one in the cycle after each cycle with `erase_flag` high. It stays unchanged otherwise and holds at 2^CNT_W-1 once that value is reached.
- R8: `erase_flag` is high only when `rd_valid` is high. When `rd_valid` is low, `rd_data` is 0.
- R9: Bit i of `flip_mask` inverts codeword bit i on a write and has no effect on reads or on other addresses.
- R10: Reads do not alter stored contents, and each address holds its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | $clog2(DEPTH) | Location for the write or read |
| wr_en | input | 1 | Write the value at `addr` (wins over `rd_en`) |
| wr_data | input | 6 | Quantized channel value to store |
| flip_mask | input | 7 | Fault-injection mask XORed into the codeword on write |
| rd_en | input | 1 | Read `addr`; data appears the next cycle |
| rd_data | output | 6 | Read value, zero when erased or not valid |
| rd_valid | output | 1 | `rd_data` holds a read result this cycle |
| erase_flag | output | 1 | The current read was erased |
| erase_count | output | CNT_W | Saturating count of erasures |

## Verification
The hardest situation to reach from the ports is a word whose contents change after it was written, since a healthy array never corrupts itself. The stimulus gets there through the write-side mask. Every 6-bit value is stored with a clean mask, with each single-bit flip and with a double flip of both top-bit copies, and then read back. The expected output and flag follow from the mask's two top bits alone. The large number of erasures this produces also drives a narrowed counter into saturation.

// File: rtl/llr_guard_pkg.sv
package llr_guard_pkg;

  localparam int unsigned LLR_W  = 6;
  localparam int unsigned CODE_W = LLR_W + 1;
  localparam int unsigned TOP    = LLR_W - 1;

  typedef logic [LLR_W-1:0]  llr_t;
  typedef logic [CODE_W-1:0] code_t;

  function automatic code_t make_code(input llr_t v);
    return {v[TOP], v};
  endfunction

  function automatic logic copies_agree(input code_t c);
    return c[CODE_W-1] == c[TOP];
  endfunction

endpackage

// File: rtl/llr_rst_sync.sv
module llr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/llr_store.sv
module llr_store
  import llr_guard_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  code_t         wr_word,
  input  logic          rd_en,
  output code_t         rd_word,
  output logic          rd_valid
);

  code_t mem [DEPTH];
  code_t word_q;
  code_t word_d;
  logic  valid_q;
  logic  valid_d;
  logic  rd_take;

  always_comb begin
    rd_take = rd_en && !wr_en;
    valid_d = rd_take;
    word_d  = rd_take ? mem[addr] : word_q;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rd_take) word_q <= word_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign rd_word  = word_q;
  assign rd_valid = valid_q;

endmodule

// File: rtl/llr_erase_check.sv
module llr_erase_check
  import llr_guard_pkg::*;
(
  input  code_t word,
  input  logic  valid,
  output llr_t  value,
  output logic  erased
);

  logic agree;

  always_comb begin
    agree  = copies_agree(word);
    erased = valid && !agree;
    value  = (valid && agree) ? word[LLR_W-1:0] : '0;
  end

endmodule

// File: rtl/llr_sat_counter.sv
module llr_sat_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc && (cnt_q != MAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/llr_guard_buffer.sv
module llr_guard_buffer
  import llr_guard_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [LLR_W-1:0]  wr_data,
  input  logic [CODE_W-1:0] flip_mask,
  input  logic              rd_en,
  output logic [LLR_W-1:0]  rd_data,
  output logic              rd_valid,
  output logic              erase_flag,
  output logic [CNT_W-1:0]  erase_count
);

  logic  rst_sync_n;
  code_t wr_word;
  code_t rd_word;
  logic  word_valid;

  llr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    wr_word = make_code(wr_data) ^ flip_mask;
  end

  llr_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .rd_en    (rd_en),
    .rd_word  (rd_word),
    .rd_valid (word_valid)
  );

  llr_erase_check u_check (
    .word   (rd_word),
    .valid  (word_valid),
    .value  (rd_data),
    .erased (erase_flag)
  );

  llr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (erase_flag),
    .count (erase_count)
  );

  assign rd_valid = word_valid;

endmodule

// File: rtl/llr_guard_checker.sv
module llr_guard_checker
  import llr_guard_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [LLR_W-1:0] rd_data,
  input logic             rd_valid,
  input logic             erase_flag,
  input logic [CNT_W-1:0] erase_count
);

  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  assert_flag_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    erase_flag |-> rd_valid);

  assert_idle_data_zero_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_valid |-> (rd_data == '0));

  assert_erased_is_zero_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    erase_flag |-> (rd_data == '0));

  assert_valid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !wr_en) |=> rd_valid);

  assert_no_valid_without_read_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(rd_en && !wr_en) |=> !rd_valid);

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (erase_flag && erase_count != MAX) |=> (erase_count == $past(erase_count) + 1'b1));

  assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!erase_flag || erase_count == MAX) |=> $stable(erase_count));

endmodule

bind llr_guard_buffer llr_guard_checker #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .erase_flag  (erase_flag),
  .erase_count (erase_count)
);

// File: tb/sim_llr_guard_buffer.sv
`timescale 1ns/1ps
module sim_llr_guard_buffer;

  localparam int DEPTH = 16;
  localparam int CNT_W = 4;
  localparam int AW    = 4;
  localparam int CMAX  = 15;

  logic            clk;
  logic            rst_n;
  logic [AW-1:0]   addr;
  logic            wr_en;
  logic [5:0]      wr_data;
  logic [6:0]      flip_mask;
  logic            rd_en;
  logic [5:0]      rd_data;
  logic            rd_valid;
  logic            erase_flag;
  logic [CNT_W-1:0] erase_count;

  int compared = 0;
  int mismatched = 0;
  int exp_cnt = 0;
  bit done = 0;

  llr_guard_buffer #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .flip_mask(flip_mask), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .erase_flag(erase_flag), .erase_count(erase_count)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input int a, input int v, input int m);
    @(negedge clk);
    addr = a[AW-1:0]; wr_data = v[5:0]; flip_mask = m[6:0]; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; flip_mask = '0;
  endtask

  task automatic do_read(input int a, input int exp_d, input int exp_f, input string req);
    @(negedge clk);
    addr = a[AW-1:0]; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    check({req, " R3 rd_valid"}, int'(rd_valid), 1);
    check({req, " data"}, int'(rd_data), exp_d);
    check({req, " flag"}, int'(erase_flag), exp_f);
    if (exp_f != 0 && exp_cnt < CMAX) exp_cnt++;
    @(negedge clk);
    check("R7 erase_count", int'(erase_count), exp_cnt);
    check("R8 idle flag", int'(erase_flag), 0);
    check("R8 idle data", int'(rd_data), 0);
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset rd_valid", int'(rd_valid), 0);
    check("R1 reset erase_flag", int'(erase_flag), 0);
    check("R1 reset erase_count", int'(erase_count), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    exp_cnt = 0;
    check("R1 after release count", int'(erase_count), 0);
    check("R1 after release rd_valid", int'(rd_valid), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    addr = '0; wr_en = 0; wr_data = '0; flip_mask = '0; rd_en = 0;
    apply_reset();

    // R2, R10: fill every address, read back twice
    for (int a = 0; a < DEPTH; a++) do_write(a, (a * 37 + 5) & 63, 0);
    for (int p = 0; p < 2; p++)
      for (int a = 0; a < DEPTH; a++) do_read(a, (a * 37 + 5) & 63, 0, "R10 retain R2");

    // R3: write wins over read in the same cycle
    @(negedge clk);
    addr = 4'd3; wr_data = 6'd42; flip_mask = '0; wr_en = 1; rd_en = 1;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check("R3 no read on collision", int'(rd_valid), 0);
    check("R8 flag on collision", int'(erase_flag), 0);
    do_read(3, 42, 0, "R3 collision write");

    // R2 R4 R5 R6 R9: every value with each mask pattern
    for (int v = 0; v < 64; v++) begin
      for (int k = 0; k < 9; k++) begin
        int m;
        int f;
        int ed;
        string tag;
        if (k == 0)      m = 0;
        else if (k < 8)  m = 1 << (k - 1);
        else             m = 7'h60;
        f  = ((m >> 5) ^ (m >> 6)) & 1;
        ed = f ? 0 : ((v ^ m) & 63);
        if (k == 0)      tag = "R2 clean";
        else if (k < 6)  tag = "R5 low flip";
        else if (k < 8)  tag = "R4 top flip";
        else             tag = "R6 double flip";
        do_write(v % DEPTH, v, m);
        do_read(v % DEPTH, ed, f, tag);
      end
    end

    // R9: mask affects only the addressed word
    do_write(0, 21, 0);
    do_write(1, 33, 7'h40);
    do_read(0, 21, 0, "R9 neighbour untouched");
    do_read(1, 0, 1, "R9 mask on target");
    @(negedge clk);
    flip_mask = 7'h7f; addr = 4'd0; rd_en = 1;
    @(negedge clk);
    rd_en = 0; flip_mask = '0;
    check("R9 mask on read data", int'(rd_data), 21);
    check("R9 mask on read flag", int'(erase_flag), 0);
    @(negedge clk);

    // R1: reset clears the saturated counter
    check("R7 saturated", int'(erase_count), CMAX);
    apply_reset();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule